// File: doc/BRIEF.md
# Single-Channel Memory-to-Stream DMA Engine

This block is one DMA channel. A processor programs it through a small register window, giving a start address and a word count, and then starts it with a control write. The engine reads 32-bit words from memory one at a time and forwards each word on a valid/ready output stream. It marks the final word with `last`. When the block is finished it raises a one-cycle completion pulse, which is meant to feed a pending bit in an interrupt controller.

The engine has three kinds of outputs. Its memory read master keeps at most one request in flight. The output stream obeys normal back-pressure: while `st_valid` is high and `st_ready` is low, the data and last flag hold steady, and a word counts as delivered only on a clock where valid and ready are both high. A busy flag and a running count of finished transfers are plain status pins.

Top module: `dma_chan_engine`

## Requirements
- R1: The register window decodes a 4-bit offset. 0x0 is the 32-bit source address. 0x4 is the word count, of which the low 16 bits are stored and the upper bits read as zero. 0x8 is control, with bit 0 showing busy. Any other offset reads zero. A read returns its data with `reg_rvalid` high for exactly one cycle, on the cycle after `reg_rd_en`.
- R2: A write to offset 0x8 with bit 0 set starts a transfer when the engine is idle. A write there with bit 0 clear starts nothing.
- R3: Word i is read from source address + 4·i, with 32-bit wraparound. Each word takes exactly one `mem_rd_en` cycle, and no new read is issued until the previous one has returned with `mem_rd_valid`.
- R4: Each returned word appears on `st_data` in read order, and only after its memory read has returned. While `st_valid` is high and `st_ready` is low, `st_data` and `st_last` hold steady. Exactly as many beats as the programmed count are delivered.
- R5: `st_last` is high on the final beat of a block and on no other beat.
- R6: `done_pulse` is high for exactly one cycle per transfer, on the cycle after the final beat is accepted.
- R7: `done_count` increases by one per finished transfer, in the cycle after `done_pulse`, and changes at no other time.
- R8: `busy` is high from the cycle after the start write through the `done_pulse` cycle, and low after that. Control bit 0 reads back as `busy`. While idle, the engine drives neither `st_valid` nor `mem_rd_en`.
- R9: A start written while busy is ignored. The running transfer is unchanged, and no second transfer or pulse follows.
- R10: Writes to the address or count registers during a transfer are stored and read back, but do not change the transfer in flight.
- R11: A start with a count of zero issues no memory read and no stream beat, yet still gives one `done_pulse` and one `done_count` increment.
- R12: Reset clears the address and count registers, `busy`, `done_count`, and any transfer in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_off | input | 4 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_master_id | output | 8 | Constant requester identifier |
| mem_rd_data | input | 32 | Memory read return data |
| mem_rd_valid | input | 1 | Memory read return valid |
| st_valid | output | 1 | Stream word valid |
| st_data | output | 32 | Stream word |
| st_last | output | 1 | Final word of the block |
| st_ready | input | 1 | Stream sink ready |
| done_pulse | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |
| done_count | output | 32 | Number of finished transfers |

## Verification
A wrong word counter shows up at the ports either as `st_last` on the wrong beat or as a beat count that differs from the programmed one. The next `done_pulse` then arrives early or late by whole beats, and `done_count` is off by the same margin. A bad address register or a broken address step shows in the first or second `mem_rd_addr` of a transfer, and so in the matching stream data, within the latency of one memory read. A stuck sequencer state shows as `busy` never falling or `st_valid` asserting while idle, both within a few cycles of the expected pulse. Faults in the busy guard show only when a start is written mid-transfer, as an extra pulse or a restarted address sequence.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int REG_W = 32;
  localparam int OFF_W = 4;

  localparam logic [OFF_W-1:0] OFF_SRC   = 4'h0;
  localparam logic [OFF_W-1:0] OFF_COUNT = 4'h4;
  localparam logic [OFF_W-1:0] OFF_CTRL  = 4'h8;
  localparam int CTRL_GO_BIT = 0;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ISSUE,
    SEQ_WAIT,
    SEQ_SEND,
    SEQ_DONE
  } seq_state_e;
endpackage

// File: rtl/dma_reg_bank.sv
module dma_reg_bank
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [OFF_W-1:0]   off,
  input  logic [REG_W-1:0]   wdata,
  input  logic               busy,
  output logic [REG_W-1:0]   rdata,
  output logic               rvalid,
  output logic [ADDR_W-1:0]  src_addr,
  output logic [COUNT_W-1:0] word_count,
  output logic               start
);
  logic [REG_W-1:0] rd_mux;

  // A start is only taken while idle; a mid-transfer start is dropped.
  assign start = wr_en && (off == OFF_CTRL) && wdata[CTRL_GO_BIT] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr   <= '0;
      word_count <= '0;
    end else if (wr_en) begin
      if (off == OFF_SRC)   src_addr   <= wdata[ADDR_W-1:0];
      if (off == OFF_COUNT) word_count <= wdata[COUNT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (off)
      OFF_SRC:   rd_mux = REG_W'(src_addr);
      OFF_COUNT: rd_mux = REG_W'(word_count);
      OFF_CTRL:  rd_mux[CTRL_GO_BIT] = busy;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dma_fetch_seq.sv
module dma_fetch_seq
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  src_addr,
  input  logic [COUNT_W-1:0] word_count,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_rd_addr,
  input  logic [DATA_W-1:0]  mem_rd_data,
  input  logic               mem_rd_valid,
  output logic               st_valid,
  output logic [DATA_W-1:0]  st_data,
  output logic               st_last,
  input  logic               st_ready,
  output logic               busy,
  output logic               done
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);
  localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

  seq_state_e state;
  logic [ADDR_W-1:0]  cur_addr;
  logic [COUNT_W-1:0] remain;
  logic [DATA_W-1:0]  word_q;
  logic               final_beat;

  assign final_beat = (remain == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      word_q   <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (start) begin
          cur_addr <= src_addr;
          remain   <= word_count;
          state    <= (word_count == '0) ? SEQ_DONE : SEQ_ISSUE;
        end
        SEQ_ISSUE: state <= SEQ_WAIT;
        SEQ_WAIT: if (mem_rd_valid) begin
          word_q <= mem_rd_data;
          state  <= SEQ_SEND;
        end
        SEQ_SEND: if (st_ready) begin
          if (final_beat) begin
            state <= SEQ_DONE;
          end else begin
            remain   <= remain - ONE;
            cur_addr <= cur_addr + ADDR_STEP;
            state    <= SEQ_ISSUE;
          end
        end
        SEQ_DONE: state <= SEQ_IDLE;
        default:  state <= SEQ_IDLE;
      endcase
    end
  end

  assign mem_rd_en   = (state == SEQ_ISSUE);
  assign mem_rd_addr = cur_addr;
  assign st_valid    = (state == SEQ_SEND);
  assign st_data     = word_q;
  assign st_last     = (state == SEQ_SEND) && final_beat;
  assign busy        = (state != SEQ_IDLE);
  assign done        = (state == SEQ_DONE);
endmodule

// File: rtl/dma_done_tally.sv
module dma_done_tally #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (done) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          COUNT_W   = 16,
  parameter int          CNT_W     = 32,
  parameter int          ID_W      = 8,
  parameter logic [7:0]  MASTER_ID = 8'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              reg_rvalid,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic [ID_W-1:0]   mem_master_id,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              mem_rd_valid,
  output logic              st_valid,
  output logic [DATA_W-1:0] st_data,
  output logic              st_last,
  input  logic              st_ready,
  output logic              done_pulse,
  output logic              busy,
  output logic [CNT_W-1:0]  done_count
);
  logic [ADDR_W-1:0]  src_addr;
  logic [COUNT_W-1:0] word_count;
  logic               start;

  assign mem_master_id = ID_W'(MASTER_ID);

  dma_reg_bank #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .rd_en(reg_rd_en), .off(reg_off), .wdata(reg_wdata),
    .busy(busy), .rdata(reg_rdata), .rvalid(reg_rvalid),
    .src_addr(src_addr), .word_count(word_count), .start(start)
  );

  dma_fetch_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COUNT_W(COUNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .src_addr(src_addr), .word_count(word_count),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid),
    .st_valid(st_valid), .st_data(st_data), .st_last(st_last), .st_ready(st_ready),
    .busy(busy), .done(done_pulse)
  );

  dma_done_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .done(done_pulse), .count(done_count)
  );
endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd_en,
  input logic              reg_rvalid,
  input logic              mem_rd_en,
  input logic              st_valid,
  input logic [DATA_W-1:0] st_data,
  input logic              st_last,
  input logic              st_ready,
  input logic              done_pulse,
  input logic              busy,
  input logic [CNT_W-1:0]  done_count
);
  p_rvalid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> reg_rvalid);
  p_rvalid_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> !reg_rvalid);
  p_single_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
  p_hold_stream_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_last)));
  p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_last |-> st_valid);
  p_one_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> (done_count == $past(done_count) + CNT_W'(1)));
  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_pulse |=> $stable(done_count));
  p_pulse_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> busy);
  p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !busy);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!st_valid && !mem_rd_en));
endmodule

bind dma_chan_engine dma_chan_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd_en(reg_rd_en), .reg_rvalid(reg_rvalid),
  .mem_rd_en(mem_rd_en), .st_valid(st_valid), .st_data(st_data),
  .st_last(st_last), .st_ready(st_ready), .done_pulse(done_pulse),
  .busy(busy), .done_count(done_count)
);

// File: tb/tb_dma_chan_engine.sv
`timescale 1ns/1ps
module tb_dma_chan_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en, reg_rd_en;
  logic [3:0]  reg_off;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_rvalid;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic [7:0]  mem_master_id;
  logic [31:0] mem_rd_data;
  logic        mem_rd_valid;
  logic        st_valid, st_last, st_ready;
  logic [31:0] st_data;
  logic        done_pulse, busy;
  logic [31:0] done_count;

  always #4 clk = ~clk;

  dma_chan_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_master_id(mem_master_id), .mem_rd_data(mem_rd_data),
    .mem_rd_valid(mem_rd_valid), .st_valid(st_valid), .st_data(st_data),
    .st_last(st_last), .st_ready(st_ready), .done_pulse(done_pulse),
    .busy(busy), .done_count(done_count)
  );

  typedef struct packed {
    logic [31:0] src;
    logic [15:0] cnt;
    logic [3:0]  lat;
    logic [1:0]  rmode;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{src: 32'h0000_1000, cnt: 16'd4, lat: 4'd1, rmode: 2'd0},
    '{src: 32'h0000_2F00, cnt: 16'd1, lat: 4'd3, rmode: 2'd1},
    '{src: 32'h8000_0010, cnt: 16'd7, lat: 4'd2, rmode: 2'd2},
    '{src: 32'h0000_0FFC, cnt: 16'd3, lat: 4'd1, rmode: 2'd1},
    '{src: 32'hFFFF_FFF8, cnt: 16'd3, lat: 4'd2, rmode: 2'd0}
  };

  int nchk = 0, nfail = 0, cyc = 0, pulses = 0;
  int rx_n = 0, rd_n = 0, lat = 1, rmode = 0;
  logic [31:0] rx_data [64];
  logic        rx_last [64];
  logic [31:0] rd_log  [64];
  bit          pend = 0;
  int          pcnt = 0;
  logic [31:0] paddr = '0;
  bit          finished = 0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[31:16] + 16'h0101};
  endfunction

  // Memory model, stream sink and pulse monitor, all on the falling edge.
  always @(negedge clk) begin
    cyc++;
    case (rmode)
      0:       st_ready = 1'b1;
      1:       st_ready = cyc[0];
      default: st_ready = (cyc % 3 == 0);
    endcase
    if (st_valid && st_ready && rx_n < 64) begin
      rx_data[rx_n] = st_data; rx_last[rx_n] = st_last; rx_n++;
    end
    if (done_pulse) pulses++;
    mem_rd_valid = 1'b0;
    if (!rst_n) pend = 0;
    else begin
      if (pend) begin
        pcnt--;
        if (pcnt == 0) begin
          mem_rd_valid = 1'b1; mem_rd_data = mem_word(paddr); pend = 0;
        end
      end
      if (mem_rd_en) begin
        pend = 1; pcnt = lat; paddr = mem_rd_addr;
        if (rd_n < 64) rd_log[rd_n] = mem_rd_addr;
        rd_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_off = off; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_off = '0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [3:0] off, output logic [31:0] d, output logic v);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_off = off;
    @(negedge clk);
    reg_rd_en = 1'b0; reg_off = '0;
    d = reg_rdata; v = reg_rvalid;
  endtask

  task automatic wait_done(input int target);
    int guard = 0;
    while (pulses < target && guard < 3000) begin
      @(negedge clk); guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_logs;
    @(negedge clk);
    rx_n = 0; rd_n = 0;
  endtask

  logic [31:0] rv;
  logic        vv;
  int          p0;
  logic [31:0] c0;

  initial begin
    rst_n = 1'b0; reg_wr_en = 0; reg_rd_en = 0; reg_off = '0; reg_wdata = '0;
    mem_rd_data = '0; mem_rd_valid = 0; st_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    chk(busy == 0, "R12 busy after reset", 32'(busy), 0);
    chk(done_count == 0, "R12 done_count after reset", done_count, 0);
    chk(!st_valid && !mem_rd_en, "R8 idle outputs quiet", {st_valid, mem_rd_en}, 0);
    chk(reg_rvalid == 0, "R1 rvalid idle", 32'(reg_rvalid), 0);

    // R1: register map and read timing
    reg_write(4'h0, 32'h1234_5678);
    reg_write(4'h4, 32'hABCD_0010);
    reg_read(4'h0, rv, vv);
    chk(vv == 1, "R1 rvalid one cycle after read", 32'(vv), 1);
    chk(rv == 32'h1234_5678, "R1 source address readback", rv, 32'h1234_5678);
    @(negedge clk);
    chk(reg_rvalid == 0, "R1 rvalid lasts one cycle", 32'(reg_rvalid), 0);
    reg_read(4'h4, rv, vv);
    chk(rv == 32'h0000_0010, "R1 count readback 16 bits", rv, 32'h0000_0010);
    reg_read(4'h8, rv, vv);
    chk(rv == 0, "R8 control bit0 idle", rv, 0);
    reg_read(4'hC, rv, vv);
    chk(rv == 0, "R1 unmapped offset reads zero", rv, 0);

    // R2: control write with bit 0 clear starts nothing
    clear_logs(); p0 = pulses;
    reg_write(4'h8, 32'hFFFF_FFFE);
    repeat (10) @(negedge clk);
    chk(busy == 0, "R2 no start on bit0 clear", 32'(busy), 0);
    chk(rd_n == 0 && pulses == p0, "R2 no read or pulse", 32'(rd_n), 0);

    // Table-driven transfers: R3..R8
    for (int k = 0; k < NVEC; k++) begin
      rmode = int'(VECS[k].rmode); lat = int'(VECS[k].lat);
      clear_logs(); p0 = pulses; c0 = done_count;
      reg_write(4'h0, VECS[k].src);
      reg_write(4'h4, 32'(VECS[k].cnt));
      reg_write(4'h8, 32'h1);
      wait_done(p0 + 1);
      chk(rx_n == int'(VECS[k].cnt), "R4 beat count", 32'(rx_n), 32'(VECS[k].cnt));
      chk(rd_n == int'(VECS[k].cnt), "R3 one read per word", 32'(rd_n), 32'(VECS[k].cnt));
      for (int i = 0; i < int'(VECS[k].cnt); i++) begin
        logic [31:0] ea;
        ea = VECS[k].src + 32'(4 * i);
        chk(rd_log[i] == ea, "R3 read address", rd_log[i], ea);
        chk(rx_data[i] == mem_word(ea), "R4 stream data", rx_data[i], mem_word(ea));
        chk(rx_last[i] == (i == int'(VECS[k].cnt) - 1), "R5 last placement",
            32'(rx_last[i]), 32'(i == int'(VECS[k].cnt) - 1));
      end
      chk(pulses == p0 + 1, "R6 one pulse per transfer", 32'(pulses - p0), 1);
      chk(done_count == c0 + 1, "R7 count increment", done_count, c0 + 1);
      chk(busy == 0, "R8 busy low after completion", 32'(busy), 0);
    end
    chk(mem_master_id == 8'd3, "R3 master id", 32'(mem_master_id), 3);

    // R9, R10, R8: writes while busy
    rmode = 1; lat = 3;
    clear_logs(); p0 = pulses; c0 = done_count;
    reg_write(4'h0, 32'h0000_3000);
    reg_write(4'h4, 32'd8);
    reg_write(4'h8, 32'h1);
    reg_read(4'h8, rv, vv);
    chk(rv == 1, "R8 control bit0 reads busy", rv, 1);
    reg_write(4'h0, 32'h0000_7000);
    reg_write(4'h4, 32'd2);
    reg_write(4'h8, 32'h1);
    wait_done(p0 + 1);
    repeat (20) @(negedge clk);
    chk(rx_n == 8, "R9 R10 running transfer unchanged", 32'(rx_n), 8);
    chk(rd_log[7] == 32'h0000_301C, "R10 address sequence kept", rd_log[7], 32'h0000_301C);
    chk(pulses == p0 + 1, "R9 no second pulse", 32'(pulses - p0), 1);
    chk(done_count == c0 + 1, "R9 count once", done_count, c0 + 1);
    reg_read(4'h0, rv, vv);
    chk(rv == 32'h0000_7000, "R10 address stored", rv, 32'h0000_7000);
    reg_read(4'h4, rv, vv);
    chk(rv == 32'd2, "R10 count stored", rv, 2);
    reg_read(4'h8, rv, vv);
    chk(rv == 0, "R8 control bit0 clear after done", rv, 0);

    // R11: zero-length transfer
    rmode = 0; lat = 1;
    clear_logs(); p0 = pulses; c0 = done_count;
    reg_write(4'h4, 32'd0);
    reg_write(4'h8, 32'h1);
    wait_done(p0 + 1);
    chk(rd_n == 0 && rx_n == 0, "R11 no read no beat", 32'(rd_n + rx_n), 0);
    chk(pulses == p0 + 1, "R11 pulse", 32'(pulses - p0), 1);
    chk(done_count == c0 + 1, "R11 count", done_count, c0 + 1);

    // R12: reset mid-transfer
    lat = 3; p0 = pulses;
    reg_write(4'h0, 32'h0000_5000);
    reg_write(4'h4, 32'd20);
    reg_write(4'h8, 32'h1);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && st_valid == 0, "R12 reset aborts transfer", {busy, st_valid}, 0);
    chk(done_count == 0, "R12 count cleared", done_count, 0);
    reg_read(4'h0, rv, vv);
    chk(rv == 0, "R12 address cleared", rv, 0);
    reg_read(4'h4, rv, vv);
    chk(rv == 0, "R12 count reg cleared", rv, 0);
    repeat (10) @(negedge clk);
    chk(pulses == p0, "R12 no pulse after reset", 32'(pulses - p0), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule